// File: doc/BRIEF.md
# SCSI Bus Phase Monitor and Interrupt Unit

This block sits beside a SCSI bus controller and watches the bus control lines for it. All incoming active-low SCSI signals are first brought into the clock domain through two-flop synchronizers and turned into active-high levels. The synchronized I/O, C/D and MSG lines are compared all the time against the phase the host has programmed as target phase bits. The result is shown as a phase-match flag in an 8-bit status image.

When the host has DMA mode enabled, a phase mismatch has three effects. It raises an interrupt at the moment REQ becomes asserted. It hides REQ from the transfer engine. It takes away the data-bus drive enable even if the host asks for the data bus to be driven. A second interrupt source watches BSY while busy monitoring is on. If BSY stays negated for a full bus-settle delay, the unit sets a busy-error flag and requests an interrupt. Both flags are sticky and stay set until the host pulses an interrupt-clear strobe. Data transfer, arbitration and selection are handled elsewhere.

Top module: `scsi_phase_watch`

## Requirements
- R1: After reset, status bits 2 (busy error) and 4 (interrupt active) are 0 and `irq_o` is 0.
- R2: Status bit 3 is 1 exactly when the synchronized phase equals `tgt_phase_i`. Bit 0 of `tgt_phase_i` is compared with I/O, bit 1 with C/D and bit 2 with MSG. The comparison runs whether or not DMA mode is on.
- R3: With `dma_mode_i` = 1, a synchronized REQ going from negated to asserted while the phases differ sets `irq_o` and status bit 4. This happens three clock edges after `req_n_i` falls.
- R4: No phase interrupt is raised in three cases: REQ rises while the phases match; REQ rises with `dma_mode_i` = 0; or a mismatch appears while REQ is already held asserted.
- R5: `req_gated_o` follows the synchronized REQ, except that it is 0 while `dma_mode_i` = 1 and the phases differ.
- R6: `db_drive_o` equals `assert_db_i`, except that it is 0 while `dma_mode_i` = 1 and the phases differ.
- R7: With `busy_mon_i` = 1, a synchronized BSY that stays negated for SETTLE_CYC consecutive cycles sets status bit 2 and the interrupt. A shorter negation restarts the count and reports nothing.
- R8: With `busy_mon_i` = 0, loss of BSY raises nothing.
- R9: Status bits 2 and 4 and `irq_o` stay set until `irq_clr_i` is sampled high, and are cleared on that clock edge.
- R10: The status image has synchronized ACK in bit 0 and ATN in bit 1. Bit 5 is `parity_err_i`, bit 6 is `dma_req_i` and bit 7 is `end_dma_i`.
- R11: A change on a SCSI input shows up in the status image after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_n_i | input | 1 | SCSI I/O line, active low |
| cd_n_i | input | 1 | SCSI C/D line, active low |
| msg_n_i | input | 1 | SCSI MSG line, active low |
| req_n_i | input | 1 | SCSI REQ line, active low |
| bsy_n_i | input | 1 | SCSI BSY line, active low |
| ack_n_i | input | 1 | SCSI ACK line, active low |
| atn_n_i | input | 1 | SCSI ATN line, active low |
| tgt_phase_i | input | 3 | Programmed phase: bit0 I/O, bit1 C/D, bit2 MSG |
| dma_mode_i | input | 1 | DMA mode enable |
| busy_mon_i | input | 1 | Busy monitoring enable |
| assert_db_i | input | 1 | Host request to drive the data bus |
| parity_err_i | input | 1 | Parity error flag from the data path |
| dma_req_i | input | 1 | DMA request flag from the data path |
| end_dma_i | input | 1 | End-of-DMA flag from the data path |
| irq_clr_i | input | 1 | Strobe that clears the sticky interrupt flags |
| status_o | output | 8 | Bus and status image |
| irq_o | output | 1 | Interrupt request |
| req_gated_o | output | 1 | REQ as seen by the transfer engine |
| db_drive_o | output | 1 | Data-bus drive enable |

## Verification
The phase comparison is swept over every value of the three phase lines against several programmed phases, so that each line is shown to be compared with its own bit and not with a neighbour. The phase interrupt is tried under four conditions: a REQ edge during a mismatch, a REQ edge during a match, a REQ edge with DMA mode off, and a mismatch that appears under a REQ already held. Only the first of these may raise it, which separates edge detection from level detection. BSY is negated once for a short glitch and once for just long enough, and the flag is sampled one cycle before and one cycle at the expected edge. This pins down the settle window exactly.

// File: rtl/scsi_pw_pkg.sv
package scsi_pw_pkg;
    // Index of each line in the synchronized signal vector
    localparam int SIG_IO  = 0;
    localparam int SIG_CD  = 1;
    localparam int SIG_MSG = 2;
    localparam int SIG_REQ = 3;
    localparam int SIG_BSY = 4;
    localparam int SIG_ACK = 5;
    localparam int SIG_ATN = 6;
    localparam int NUM_SIG = 7;

    // Status image bit positions
    localparam int ST_ACK    = 0;
    localparam int ST_ATN    = 1;
    localparam int ST_BSYERR = 2;
    localparam int ST_MATCH  = 3;
    localparam int ST_IRQ    = 4;
    localparam int ST_PARITY = 5;
    localparam int ST_DMAREQ = 6;
    localparam int ST_ENDDMA = 7;

    typedef struct packed {
        logic irq;
        logic bsy_err;
    } flag_t;
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_n_i,
    output logic [W-1:0] level_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = line_n_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '1, s2: '1};
        end else begin
            st_q <= st_d;
        end
    end

    // Each line becomes an active-high level after the second stage
    for (genvar i = 0; i < W; i++) begin : g_inv
        assign level_o[i] = ~st_q.s2[i];
    end
endmodule

// File: rtl/pw_phase_check.sv
module pw_phase_check (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] phase_i,
    input  logic [2:0] tgt_i,
    input  logic       req_i,
    input  logic       dma_mode_i,
    output logic       match_o,
    output logic       block_o,
    output logic       mm_edge_o
);
    logic req_prev_d, req_prev_q;
    logic req_rise;

    always_comb begin
        match_o    = (phase_i == tgt_i);
        block_o    = dma_mode_i & ~match_o;
        req_rise   = req_i & ~req_prev_q;
        mm_edge_o  = req_rise & block_o;
        req_prev_d = req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_prev_q <= 1'b0;
        end else begin
            req_prev_q <= req_prev_d;
        end
    end

    // R4: a held REQ never produces a phase event
    a_r4_no_event_on_held_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_prev_q |-> !mm_edge_o);
endmodule

// File: rtl/pw_busy_timer.sv
module pw_busy_timer #(
    parameter int SETTLE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bsy_i,
    output logic loss_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] TOP  = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        loss_o = en_i & ~bsy_i & (cnt_q == LAST);
        if (!en_i || bsy_i) begin
            cnt_d = '0;
        end else if (cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: BSY seen true always restarts the window
    a_r7_restart_on_bsy: assert property (@(posedge clk) disable iff (!rst_n)
        bsy_i |=> (cnt_q == '0));
endmodule

// File: rtl/scsi_phase_watch.sv
module scsi_phase_watch #(
    parameter int SETTLE_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_n_i,
    input  logic       cd_n_i,
    input  logic       msg_n_i,
    input  logic       req_n_i,
    input  logic       bsy_n_i,
    input  logic       ack_n_i,
    input  logic       atn_n_i,
    input  logic [2:0] tgt_phase_i,
    input  logic       dma_mode_i,
    input  logic       busy_mon_i,
    input  logic       assert_db_i,
    input  logic       parity_err_i,
    input  logic       dma_req_i,
    input  logic       end_dma_i,
    input  logic       irq_clr_i,
    output logic [7:0] status_o,
    output logic       irq_o,
    output logic       req_gated_o,
    output logic       db_drive_o
);
    import scsi_pw_pkg::*;

    logic [NUM_SIG-1:0] raw_n, lvl;
    logic [2:0]         phase;
    logic               match, block, mm_edge, loss;
    flag_t              fl_d, fl_q;

    always_comb begin
        raw_n          = '1;
        raw_n[SIG_IO]  = io_n_i;
        raw_n[SIG_CD]  = cd_n_i;
        raw_n[SIG_MSG] = msg_n_i;
        raw_n[SIG_REQ] = req_n_i;
        raw_n[SIG_BSY] = bsy_n_i;
        raw_n[SIG_ACK] = ack_n_i;
        raw_n[SIG_ATN] = atn_n_i;
    end

    pw_sync #(.W(NUM_SIG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n_i (raw_n),
        .level_o  (lvl)
    );

    assign phase = {lvl[SIG_MSG], lvl[SIG_CD], lvl[SIG_IO]};

    pw_phase_check u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .tgt_i      (tgt_phase_i),
        .req_i      (lvl[SIG_REQ]),
        .dma_mode_i (dma_mode_i),
        .match_o    (match),
        .block_o    (block),
        .mm_edge_o  (mm_edge)
    );

    pw_busy_timer #(.SETTLE_CYC(SETTLE_CYC)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy_mon_i),
        .bsy_i  (lvl[SIG_BSY]),
        .loss_o (loss)
    );

    always_comb begin
        fl_d         = fl_q;
        fl_d.bsy_err = loss | (fl_q.bsy_err & ~irq_clr_i);
        fl_d.irq     = mm_edge | loss | (fl_q.irq & ~irq_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    always_comb begin
        status_o             = '0;
        status_o[ST_ACK]     = lvl[SIG_ACK];
        status_o[ST_ATN]     = lvl[SIG_ATN];
        status_o[ST_BSYERR]  = fl_q.bsy_err;
        status_o[ST_MATCH]   = match;
        status_o[ST_IRQ]     = fl_q.irq;
        status_o[ST_PARITY]  = parity_err_i;
        status_o[ST_DMAREQ]  = dma_req_i;
        status_o[ST_ENDDMA]  = end_dma_i;
        irq_o                = fl_q.irq;
        req_gated_o          = lvl[SIG_REQ] & ~block;
        db_drive_o           = assert_db_i & ~block;
    end

    // R3: a REQ edge during a DMA mismatch raises the interrupt
    a_r3_irq_on_mismatch_edge: assert property (@(posedge clk) disable iff (!rst_n)
        mm_edge |=> irq_o);
    // R9: flags hold until cleared
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);
    // R8: busy error only rises while monitoring is enabled
    a_r8_bsyerr_needs_monitor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ST_BSYERR]) |-> $past(busy_mon_i));
    // R6: no data-bus drive while a DMA mismatch is shown
    a_r6_no_drive_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode_i && !status_o[ST_MATCH]) |-> !db_drive_o);
    // R5: REQ hidden during a DMA mismatch
    a_r5_req_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode_i && !status_o[ST_MATCH]) |-> !req_gated_o);
endmodule

// File: tb/tb_scsi_phase_watch.sv
module tb_scsi_phase_watch;
    localparam int SETTLE = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_n = 1'b1, cd_n = 1'b1, msg_n = 1'b1, req_n = 1'b1;
    logic bsy_n = 1'b0, ack_n = 1'b1, atn_n = 1'b1;
    logic [2:0] tgt = 3'b000;
    logic dma_mode = 1'b0, busy_mon = 1'b0, assert_db = 1'b0;
    logic parity_err = 1'b0, dma_req = 1'b0, end_dma = 1'b0, irq_clr = 1'b0;
    logic [7:0] status;
    logic irq, req_gated, db_drive;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    scsi_phase_watch #(.SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n),
        .io_n_i(io_n), .cd_n_i(cd_n), .msg_n_i(msg_n), .req_n_i(req_n),
        .bsy_n_i(bsy_n), .ack_n_i(ack_n), .atn_n_i(atn_n),
        .tgt_phase_i(tgt), .dma_mode_i(dma_mode), .busy_mon_i(busy_mon),
        .assert_db_i(assert_db), .parity_err_i(parity_err), .dma_req_i(dma_req),
        .end_dma_i(end_dma), .irq_clr_i(irq_clr),
        .status_o(status), .irq_o(irq), .req_gated_o(req_gated), .db_drive_o(db_drive)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_phase(input logic [2:0] p);
        io_n = ~p[0]; cd_n = ~p[1]; msg_n = ~p[2];
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1; wcyc(1); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        wcyc(3); rst_n = 1'b1; wcyc(3);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 status bits 2,4", {6'd0, status[4], status[2]}, 8'd0);
    endtask

    task automatic t_match();
        for (int t = 0; t < 8; t += 3) begin
            tgt = 3'(t);
            for (int p = 0; p < 8; p++) begin
                set_phase(3'(p));
                wcyc(3);
                chk("R2 phase match", {7'd0, status[3]}, {7'd0, (p == t)});
            end
        end
        dma_mode = 1'b1; tgt = 3'b101; set_phase(3'b101); wcyc(3);
        chk("R2 match with DMA on", {7'd0, status[3]}, 8'd1);
        dma_mode = 1'b0;
    endtask

    task automatic t_irq_edge();
        tgt = 3'b001; set_phase(3'b000); dma_mode = 1'b1; req_n = 1'b1;
        wcyc(3); clear_irq();
        chk("R3 no irq before REQ", {7'd0, irq}, 8'd0);
        req_n = 1'b0;
        wcyc(2);
        chk("R3 irq latency not yet", {7'd0, irq}, 8'd0);
        chk("R5 REQ hidden on mismatch", {7'd0, req_gated}, 8'd0);
        wcyc(1);
        chk("R3 irq on third edge", {7'd0, irq}, 8'd1);
        chk("R3 status bit 4", {7'd0, status[4]}, 8'd1);
        req_n = 1'b1; wcyc(3); clear_irq();
    endtask

    task automatic t_no_irq();
        // REQ rise while matching
        tgt = 3'b010; set_phase(3'b010); dma_mode = 1'b1; wcyc(3); clear_irq();
        req_n = 1'b0; wcyc(4);
        chk("R4 no irq on match", {7'd0, irq}, 8'd0);
        chk("R5 REQ passes on match", {7'd0, req_gated}, 8'd1);
        // mismatch appears under held REQ
        set_phase(3'b110); wcyc(5);
        chk("R4 no irq on held REQ", {7'd0, irq}, 8'd0);
        chk("R5 REQ hidden held", {7'd0, req_gated}, 8'd0);
        req_n = 1'b1; wcyc(3);
        // REQ rise with DMA off
        dma_mode = 1'b0; req_n = 1'b0; wcyc(4);
        chk("R4 no irq with DMA off", {7'd0, irq}, 8'd0);
        chk("R5 REQ passes DMA off", {7'd0, req_gated}, 8'd1);
        req_n = 1'b1; wcyc(3);
    endtask

    task automatic t_drive();
        assert_db = 1'b1; tgt = 3'b100; set_phase(3'b000); dma_mode = 1'b1; wcyc(3);
        chk("R6 drive off on mismatch", {7'd0, db_drive}, 8'd0);
        set_phase(3'b100); wcyc(3);
        chk("R6 drive on match", {7'd0, db_drive}, 8'd1);
        set_phase(3'b000); dma_mode = 1'b0; wcyc(3);
        chk("R6 drive DMA off", {7'd0, db_drive}, 8'd1);
        assert_db = 1'b0; wcyc(1);
        chk("R6 no request no drive", {7'd0, db_drive}, 8'd0);
    endtask

    task automatic t_busy();
        clear_irq();
        busy_mon = 1'b1; bsy_n = 1'b0; wcyc(3);
        bsy_n = 1'b1; wcyc(10); bsy_n = 1'b0; wcyc(30);
        chk("R7 short loss ignored", {7'd0, status[2]}, 8'd0);
        bsy_n = 1'b1; wcyc(SETTLE + 1);
        chk("R7 one cycle before settle", {6'd0, irq, status[2]}, 8'd0);
        wcyc(1);
        chk("R7 busy error set", {6'd0, irq, status[2]}, 8'd3);
        bsy_n = 1'b0; wcyc(10);
        chk("R9 busy error sticky", {6'd0, status[4], status[2]}, 8'd3);
        clear_irq();
        chk("R9 cleared by strobe", {5'd0, irq, status[4], status[2]}, 8'd0);
    endtask

    task automatic t_busy_off();
        busy_mon = 1'b0; bsy_n = 1'b1; wcyc(SETTLE * 3);
        chk("R8 no busy error when off", {6'd0, irq, status[2]}, 8'd0);
        bsy_n = 1'b0; wcyc(3);
    endtask

    task automatic t_pass();
        ack_n = 1'b0; atn_n = 1'b1; parity_err = 1'b1; dma_req = 1'b0; end_dma = 1'b1;
        wcyc(1);
        chk("R11 ACK not yet after one edge", {7'd0, status[0]}, 8'd0);
        wcyc(1);
        chk("R11 ACK after two edges", {7'd0, status[0]}, 8'd1);
        chk("R10 layout", {status[7:5], status[1:0]}, {3'b101, 2'b01});
        ack_n = 1'b1; atn_n = 1'b0; parity_err = 1'b0; dma_req = 1'b1; end_dma = 1'b0;
        wcyc(2);
        chk("R10 layout swapped", {status[7:5], status[1:0]}, {3'b010, 2'b10});
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_match();
        t_irq_edge();
        t_no_irq();
        t_drive();
        t_busy();
        t_busy_off();
        t_pass();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule